// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector load or store instruction into a stream of element addresses. When it accepts an instruction it captures the base address, a byte stride, an addressing mode, a run-time element count and a per-element enable mask. It then waits a fixed start-up interval. After that it emits one element slot per clock, in element order, until the requested count is used up.

There are three ways to form an address. Consecutive 8-byte elements give a unit-stride walk. A byte stride taken from a scalar operand gives a constant-stride walk. An offset read from an index vector gives a gather or scatter. In indexed mode the block names the element it needs on `idx_sel`, and the register file side returns that element's offset on `idx_data` in the same cycle. Elements whose mask bit is clear still use their slot, but the block does not mark them valid. A one-cycle `done` pulse closes each instruction. Only after that pulse can the next instruction be accepted.

Top module: `vec_agu`

## Requirements
- R1: With mode code 0 (unit stride), the slot for element i carries address base + 8*i, modulo 2^ADDR_W.
- R2: With mode code 1 (strided), the slot for element i carries address base + i*stride, where stride is a byte count in two's complement, modulo 2^ADDR_W.
- R3: With mode code 2 (indexed), `idx_sel` equals i in the cycle before element i's slot, and that slot carries base + the value on `idx_data` in that cycle.
- R4: An instruction yields exactly min(vlen, MAX_VL) slots. They occupy consecutive cycles and carry element numbers 0, 1, 2 and so on.
- R5: `addr_valid` is high in a slot exactly when bit i of the captured mask is set, where i is that slot's element number. A slot whose bit is clear still takes its cycle.
- R6: If `start` is sampled at clock edge E, the slot for element 0 appears after edge E+STARTUP (12 by default) and no slot appears before it.
- R7: For a nonzero count n, `busy` is high from edge E until edge E+STARTUP+n. At that edge `busy` falls and `done` goes high for exactly one cycle.
- R8: A vlen of 0 produces `done` after edge E itself, with no slot, and `busy` never rises.
- R9: `start` is ignored while `busy` is high. The base, stride, mode, count and mask are captured at acceptance, so later changes on those inputs do not alter the running stream.
- R10: Mode code 3 behaves as unit stride.
- R11: While reset is held, `slot`, `addr_valid`, `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an instruction, taken only when not busy |
| mode | input | 2 | Addressing mode: 0 unit, 1 strided, 2 indexed, 3 unit |
| base | input | ADDR_W | Base byte address |
| stride | input | ADDR_W | Byte stride for strided mode |
| vlen | input | clog2(MAX_VL+1) | Requested element count, clamped to MAX_VL |
| mask | input | MAX_VL | Per-element enable, bit i for element i |
| idx_data | input | ADDR_W | Offset of the element named by idx_sel |
| idx_sel | output | clog2(MAX_VL) | Element number whose index offset is needed |
| slot | output | 1 | An element slot is on the outputs this cycle |
| addr_valid | output | 1 | The slot is enabled by the mask |
| addr | output | ADDR_W | Byte address of the element |
| elem | output | clog2(MAX_VL) | Element number of the slot |
| done | output | 1 | One-cycle end-of-instruction pulse |
| busy | output | 1 | An instruction is in progress |

## Verification
Unit-stride runs sweep every count from 0 to 64 with a full mask. This pins down the clamp-free count, the exact start-up delay and the position of the end pulse for every length, and it covers the zero-length case. Strided runs use zero, positive, odd-sized and negative strides, which separate a true per-element step from a fixed 8-byte increment and show that wrap-around arithmetic is handled. Indexed runs read from an index table filled with irregular values, so any pairing of the wrong offset with an element shows up. Mask patterns (alternating, a single bit, all clear, an irregular word), an over-length count, mode code 3, and a run that changes its inputs and re-requests mid-stream show that gating, clamping and capture at acceptance each work on their own.

// File: rtl/vagu_pkg.sv
package vagu_pkg;

    typedef enum logic [1:0] {
        AM_UNIT     = 2'd0,
        AM_STRIDE   = 2'd1,
        AM_INDEX    = 2'd2,
        AM_UNIT_ALT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_RUN  = 2'd2,
        SQ_FIN  = 2'd3
    } seq_e;

endpackage

// File: rtl/vagu_ctrl.sv
module vagu_ctrl
    import vagu_pkg::*;
#(
    parameter int MAX_VL  = 64,
    parameter int STARTUP = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAX_VL+1)-1:0]  vlen_in,
    input  logic [MAX_VL-1:0]            mask_in,
    output logic                         launch,
    output logic                         emit,
    output logic [$clog2(MAX_VL)-1:0]    cur_idx,
    output logic                         slot_o,
    output logic                         valid_o,
    output logic [$clog2(MAX_VL)-1:0]    elem_o,
    output logic                         done_o,
    output logic                         busy_o
);

    localparam int VL_W  = $clog2(MAX_VL + 1);
    localparam int IDX_W = $clog2(MAX_VL);
    localparam int CNT_W = (STARTUP > 2) ? $clog2(STARTUP) : 1;

    typedef struct packed {
        seq_e              st;
        logic [CNT_W-1:0]  wcnt;
        logic [IDX_W-1:0]  eidx;
        logic [IDX_W-1:0]  lastidx;
        logic [MAX_VL-1:0] mask;
        logic              slot;
        logic              valid;
        logic [IDX_W-1:0]  elem;
        logic              done;
    } ctrl_t;

    ctrl_t d, q;
    logic [VL_W-1:0] count;

    always_comb begin
        count  = (vlen_in > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen_in;
        d      = q;
        d.slot  = 1'b0;
        d.valid = 1'b0;
        d.done  = 1'b0;
        launch = 1'b0;
        emit   = 1'b0;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    launch = 1'b1;
                    d.mask = mask_in;
                    if (count == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st      = SQ_WAIT;
                        d.wcnt    = CNT_W'(STARTUP - 2);
                        d.eidx    = '0;
                        d.lastidx = IDX_W'(count - VL_W'(1));
                    end
                end
            end
            SQ_WAIT: begin
                if (q.wcnt == '0) begin
                    d.st = SQ_RUN;
                end else begin
                    d.wcnt = q.wcnt - CNT_W'(1);
                end
            end
            SQ_RUN: begin
                emit    = 1'b1;
                d.slot  = 1'b1;
                d.valid = q.mask[q.eidx];
                d.elem  = q.eidx;
                if (q.eidx == q.lastidx) begin
                    d.st = SQ_FIN;
                end else begin
                    d.eidx = q.eidx + IDX_W'(1);
                end
            end
            default: begin
                d.done = 1'b1;
                d.st   = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: SQ_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign cur_idx = q.eidx;
    assign slot_o  = q.slot;
    assign valid_o = q.valid;
    assign elem_o  = q.elem;
    assign done_o  = q.done;
    assign busy_o  = (q.st != SQ_IDLE);

endmodule

// File: rtl/vagu_addr.sv
module vagu_addr
    import vagu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int ELEM_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              emit,
    input  logic [1:0]        mode_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] stride_in,
    input  logic [ADDR_W-1:0] idx_data,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        amode_e            mode;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] step;
        logic [ADDR_W-1:0] acc;
        logic [ADDR_W-1:0] addr;
    } addr_t;

    addr_t d, q;

    always_comb begin
        d = q;
        if (launch) begin
            d.mode = amode_e'(mode_in);
            d.base = base_in;
            d.acc  = base_in;
            d.step = (amode_e'(mode_in) == AM_STRIDE) ? stride_in
                                                       : ADDR_W'(ELEM_BYTES);
        end else if (emit) begin
            d.addr = (q.mode == AM_INDEX) ? (q.base + idx_data) : q.acc;
            d.acc  = q.acc + q.step;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{mode: AM_UNIT, default: '0};
        end else begin
            q <= d;
        end
    end

    assign addr_o = q.addr;

endmodule

// File: rtl/vec_agu.sv
module vec_agu #(
    parameter int ADDR_W     = 32,
    parameter int MAX_VL     = 64,
    parameter int ELEM_BYTES = 8,
    parameter int STARTUP    = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode,
    input  logic [ADDR_W-1:0]           base,
    input  logic [ADDR_W-1:0]           stride,
    input  logic [$clog2(MAX_VL+1)-1:0] vlen,
    input  logic [MAX_VL-1:0]           mask,
    input  logic [ADDR_W-1:0]           idx_data,
    output logic [$clog2(MAX_VL)-1:0]   idx_sel,
    output logic                        slot,
    output logic                        addr_valid,
    output logic [ADDR_W-1:0]           addr,
    output logic [$clog2(MAX_VL)-1:0]   elem,
    output logic                        done,
    output logic                        busy
);

    localparam int IDX_W = $clog2(MAX_VL);

    logic             launch;
    logic             emit;
    logic [IDX_W-1:0] cur_idx;

    vagu_ctrl #(
        .MAX_VL  (MAX_VL),
        .STARTUP (STARTUP)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .vlen_in (vlen),
        .mask_in (mask),
        .launch  (launch),
        .emit    (emit),
        .cur_idx (cur_idx),
        .slot_o  (slot),
        .valid_o (addr_valid),
        .elem_o  (elem),
        .done_o  (done),
        .busy_o  (busy)
    );

    vagu_addr #(
        .ADDR_W     (ADDR_W),
        .ELEM_BYTES (ELEM_BYTES)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .emit      (emit),
        .mode_in   (mode),
        .base_in   (base),
        .stride_in (stride),
        .idx_data  (idx_data),
        .addr_o    (addr)
    );

    assign idx_sel = cur_idx;

endmodule

// File: rtl/vagu_chk.sv
module vagu_chk #(
    parameter int MAX_VL = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic [$clog2(MAX_VL+1)-1:0] vlen,
    input logic                        slot,
    input logic                        addr_valid,
    input logic [$clog2(MAX_VL)-1:0]   elem,
    input logic                        done,
    input logic                        busy
);

    localparam int IDX_W = $clog2(MAX_VL);

    p_valid_in_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> slot);

    p_elem_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && $past(slot)) |-> (elem == $past(elem) + IDX_W'(1)));

    p_first_elem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot) |-> (elem == '0));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_slot_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slot |-> busy);

    p_quiet_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !slot);

    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen == '0) |=> (done && !busy));

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r11: assert (!slot && !addr_valid && !done && !busy);
        end
    end

endmodule

bind vec_agu vagu_chk #(.MAX_VL(MAX_VL)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .vlen       (vlen),
    .slot       (slot),
    .addr_valid (addr_valid),
    .elem       (elem),
    .done       (done),
    .busy       (busy)
);

// File: tb/vec_agu_test.sv
module vec_agu_test;

    localparam int STARTUP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] base = '0;
    logic [31:0] stride = '0;
    logic [6:0]  vlen = '0;
    logic [63:0] mask = '0;
    logic [31:0] idx_data;
    logic [5:0]  idx_sel;
    logic        slot, addr_valid, done, busy;
    logic [31:0] addr;
    logic [5:0]  elem;

    logic [31:0] idx_mem [64];
    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign idx_data = idx_mem[idx_sel];

    vec_agu uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .stride(stride), .vlen(vlen), .mask(mask), .idx_data(idx_data),
        .idx_sel(idx_sel), .slot(slot), .addr_valid(addr_valid), .addr(addr),
        .elem(elem), .done(done), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] md, input logic [31:0] b,
                       input logic [31:0] st, input int vl,
                       input logic [63:0] mk, input string areq,
                       input bit poke);
        int n = (vl > 64) ? 64 : vl;
        int last_k = (n == 0) ? 1 : STARTUP + n + 1;
        @(negedge clk);
        mode = md; base = b; stride = st; vlen = 7'(vl); mask = mk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= last_k; k++) begin
            bit exp_slot = (n > 0) && (k >= STARTUP) && (k < STARTUP + n);
            bit exp_busy = (n > 0) && (k < STARTUP + n);
            bit exp_done = (n == 0) ? (k == 0) : (k == STARTUP + n);
            check(slot == exp_slot, "R6", "slot", 32'(slot), 32'(exp_slot));
            check(busy == exp_busy, "R7", "busy", 32'(busy), 32'(exp_busy));
            if (n == 0)
                check(done == exp_done, "R8", "done", 32'(done), 32'(exp_done));
            else
                check(done == exp_done, "R7", "done", 32'(done), 32'(exp_done));
            if (exp_slot) begin
                int e = k - STARTUP;
                logic [31:0] ea;
                case (md)
                    2'd1:    ea = b + st * 32'(e);
                    2'd2:    ea = b + idx_mem[e];
                    default: ea = b + 32'(8 * e);
                endcase
                check(elem == 6'(e), "R4", "elem", 32'(elem), 32'(e));
                check(addr_valid == mk[e], "R5", "addr_valid",
                      32'(addr_valid), 32'(mk[e]));
                check(addr == ea, areq, "addr", addr, ea);
            end
            if (poke && n > 0) begin
                if (k == 2) begin
                    start = 1'b1; base = ~b; stride = st + 32'd4;
                    mode = 2'd1; vlen = 7'd3; mask = '0;
                end else if (k == 3) begin
                    start = 1'b0;
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++)
            idx_mem[i] = (32'(i) * 32'd37) ^ (32'(i) << 9) ^ 32'h0000_5a5a;

        repeat (3) @(negedge clk);
        // R11: outputs quiet during reset
        check(!slot && !addr_valid && !done && !busy, "R11", "reset outputs",
              {28'd0, slot, addr_valid, done, busy}, 32'd0);
        rst_n = 1'b1;

        // R1, R4, R6, R7, R8: unit stride over every count
        for (int v = 0; v <= 64; v++)
            run(2'd0, 32'h1000_0000 + 32'(v * 4096), 32'd0, v, '1, "R1", 1'b0);
        // R4: over-length count clamps to 64
        run(2'd0, 32'hFFFF_FF00, 32'd0, 70, '1, "R1", 1'b0);

        // R2: strided, several strides including zero and negative
        run(2'd1, 32'h0000_2000, 32'd0,          9,  '1, "R2", 1'b0);
        run(2'd1, 32'h0000_2000, 32'd16,         17, '1, "R2", 1'b0);
        run(2'd1, 32'h0000_0040, 32'hFFFF_FFF8,  64, '1, "R2", 1'b0);
        run(2'd1, 32'h8000_0000, 32'd100,        5,  '1, "R2", 1'b0);
        run(2'd1, 32'hFFFF_FFF0, 32'd24,         33, '1, "R2", 1'b0);

        // R3: indexed gather/scatter
        run(2'd2, 32'h4000_0000, 32'd0, 64, '1, "R3", 1'b0);
        run(2'd2, 32'hFFFF_0000, 32'd0, 31, '1, "R3", 1'b0);

        // R5: mask patterns
        run(2'd0, 32'h0000_0100, 32'd0, 64, 64'hAAAA_AAAA_AAAA_AAAA, "R1", 1'b0);
        run(2'd1, 32'h0000_0100, 32'd12, 40, 64'h1 << 20, "R2", 1'b0);
        run(2'd2, 32'h0000_0100, 32'd0, 64, 64'h0, "R3", 1'b0);
        run(2'd0, 32'h0000_0100, 32'd0, 50, 64'h9C31_07E5_D2A8_4F16, "R1", 1'b0);

        // R10: mode code 3 acts as unit stride
        run(2'd3, 32'h0123_4560, 32'd40, 20, '1, "R10", 1'b0);

        // R9: re-request and operand changes while busy are ignored
        run(2'd2, 32'h0000_8000, 32'd0, 10, 64'h2F5, "R9", 1'b1);
        run(2'd0, 32'h0000_9000, 32'd0, 6,  '1,      "R9", 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule